// File: doc/BRIEF.md
# Double-and-Add Scalar Multiplication Sequencer

This block sequences the computation of Q = kP on a binary elliptic curve. It scans the scalar k from the most significant bit to the least significant bit. For every bit it doubles the accumulator, and when the bit is set it then adds the base point P. The block does no field arithmetic. It hands each point operation to an external point unit over a request/done handshake and stores the results in its accumulator.

The accumulator can hold the point at infinity, and the block tracks this with a flag. Doubling infinity gives infinity, so no operation is issued for it. The first add onto an infinity accumulator is done by copying P directly. Because of this, the point unit never sees the neutral element as an operand. A one-cycle start pulse latches the scalar and the base point. A one-cycle done pulse marks the end of the run. The result then stays on the outputs until the next accepted start.

Top module: `scalar_mult_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and op_req_o are 0 and q_inf_o is 1.
- R2: A start_i pulse while idle latches scalar_i and the base point and sets the accumulator to infinity. Bits are then processed from index KW-1 down to 0, one iteration per bit, so the final accumulator equals k·P.
- R3: Each iteration first doubles the accumulator. It then adds P only when the current scalar bit is 1. For a nonzero k whose highest set bit is at index m, exactly m double commands and popcount(k)-1 add commands are issued.
- R4: While the accumulator is at infinity, the doubling step issues no command and the accumulator stays at infinity.
- R5: When the bit is 1 and the accumulator is at infinity, P is copied into the accumulator without a command and the infinity flag clears.
- R6: A command raises op_req_o, with op_cmd_o = 0 for double and 1 for add. The command and all operands stay steady until op_done_i is seen, and only one command is outstanding at a time. A double presents Q on both operand ports A and B. An add presents Q on A and P on B. No command is ever issued with an infinity operand.
- R7: done_o pulses high for exactly one cycle once bit 0 has been processed, and busy_o is already low in that cycle. q_x_o, q_y_o and q_inf_o stay unchanged until the next accepted start.
- R8: A start_i pulse while busy_o is high is ignored and does not change the running result.
- R9: For k = 0 no command is issued, done_o still pulses, and the result has q_inf_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| scalar_i | input | KW | Scalar k, latched on an accepted start |
| base_x_i | input | CW | Base point x coordinate, latched on start |
| base_y_i | input | CW | Base point y coordinate, latched on start |
| op_req_o | output | 1 | Point operation request, held until done |
| op_cmd_o | output | 1 | 0 = double, 1 = add |
| op_ax_o | output | CW | Operand A x |
| op_ay_o | output | CW | Operand A y |
| op_bx_o | output | CW | Operand B x |
| op_by_o | output | CW | Operand B y |
| op_done_i | input | 1 | Point unit completion pulse |
| op_rx_i | input | CW | Result x, valid with op_done_i |
| op_ry_i | input | CW | Result y, valid with op_done_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| q_x_o | output | CW | Accumulator x |
| q_y_o | output | CW | Accumulator y |
| q_inf_o | output | 1 | Accumulator is the point at infinity |

## Verification
The assertions check the following on every cycle:
- the request and its operands hold steady until completion;
- no request is ever raised while the accumulator is at infinity or while idle;
- the done pulse lasts one cycle;
- the result is frozen while idle.

Only the bench scenarios can show that the final point equals k·P. They also show that the number of double and add commands matches the scalar's bit pattern, and that a start during a run leaves the result untouched. To do this, the bench models the point unit as addition modulo a prime with random latency. It drives all-zero, single-bit, top-bit-only and all-ones scalars in addition to random ones.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DBL      = 3'd1,
        ST_DBL_WAIT = 3'd2,
        ST_ADD      = 3'd3,
        ST_ADD_WAIT = 3'd4,
        ST_STEP     = 3'd5
    } ctl_state_e;

    typedef enum logic {
        OP_DOUBLE = 1'b0,
        OP_ADD    = 1'b1
    } op_cmd_e;

    // Width of a bit index counter for a scalar of kw bits (at least 1).
    function automatic int idx_width(input int kw);
        return (kw > 1) ? $clog2(kw) : 1;
    endfunction

endpackage

// File: rtl/smul_scan.sv
module smul_scan
    import smul_pkg::*;
#(
    parameter int KW = 233
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [KW-1:0] k_in,
    input  logic          advance,
    output logic          bit_o,
    output logic          last_o
);
    localparam int IW = idx_width(KW);
    localparam logic [IW-1:0] TOP_IDX = IW'(KW - 1);

    logic [KW-1:0] sreg_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            sreg_q <= k_in;
            idx_q  <= TOP_IDX;
        end else if (advance) begin
            sreg_q <= {sreg_q[KW-2:0], 1'b0};
            idx_q  <= idx_q - 1'b1;
        end
    end

    assign bit_o  = sreg_q[KW-1];
    assign last_o = (idx_q == '0);
endmodule

// File: rtl/smul_acc.sv
module smul_acc #(
    parameter int CW = 233
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          copy_en,
    input  logic [CW-1:0] copy_x,
    input  logic [CW-1:0] copy_y,
    input  logic          res_en,
    input  logic [CW-1:0] res_x,
    input  logic [CW-1:0] res_y,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          inf_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            x_o   <= '0;
            y_o   <= '0;
            inf_o <= 1'b1;
        end else if (clear) begin
            x_o   <= '0;
            y_o   <= '0;
            inf_o <= 1'b1;
        end else if (copy_en) begin
            x_o   <= copy_x;
            y_o   <= copy_y;
            inf_o <= 1'b0;
        end else if (res_en) begin
            x_o   <= res_x;
            y_o   <= res_y;
            inf_o <= 1'b0;
        end
    end
endmodule

// File: rtl/smul_opport.sv
module smul_opport
    import smul_pkg::*;
#(
    parameter int CW = 233
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  op_cmd_e       launch_cmd,
    input  logic [CW-1:0] a_x,
    input  logic [CW-1:0] a_y,
    input  logic [CW-1:0] b_x,
    input  logic [CW-1:0] b_y,
    input  logic          done_i,
    output logic          req_o,
    output op_cmd_e       cmd_o,
    output logic [CW-1:0] ax_o,
    output logic [CW-1:0] ay_o,
    output logic [CW-1:0] bx_o,
    output logic [CW-1:0] by_o,
    output logic          fin_o
);
    assign fin_o = req_o && done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o <= 1'b0;
            cmd_o <= OP_DOUBLE;
            ax_o  <= '0;
            ay_o  <= '0;
            bx_o  <= '0;
            by_o  <= '0;
        end else if (fin_o) begin
            req_o <= 1'b0;
        end else if (launch && !req_o) begin
            req_o <= 1'b1;
            cmd_o <= launch_cmd;
            ax_o  <= a_x;
            ay_o  <= a_y;
            bx_o  <= b_x;
            by_o  <= b_y;
        end
    end
endmodule

// File: rtl/scalar_mult_ctrl.sv
module scalar_mult_ctrl
    import smul_pkg::*;
#(
    parameter int KW = 233,
    parameter int CW = 233
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [KW-1:0] scalar_i,
    input  logic [CW-1:0] base_x_i,
    input  logic [CW-1:0] base_y_i,
    output logic          op_req_o,
    output logic          op_cmd_o,
    output logic [CW-1:0] op_ax_o,
    output logic [CW-1:0] op_ay_o,
    output logic [CW-1:0] op_bx_o,
    output logic [CW-1:0] op_by_o,
    input  logic          op_done_i,
    input  logic [CW-1:0] op_rx_i,
    input  logic [CW-1:0] op_ry_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] q_x_o,
    output logic [CW-1:0] q_y_o,
    output logic          q_inf_o
);
    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
    } point_t;

    ctl_state_e state_q, state_d;
    point_t     base_q;
    point_t     acc;
    logic       acc_inf;
    logic       cur_bit, last_bit;
    logic       accept, scan_adv, copy_en, launch, op_fin, done_q;
    op_cmd_e    launch_cmd, cmd_q;
    point_t     opnd_b;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign scan_adv = (state_q == ST_STEP) && !last_bit;
    assign copy_en  = (state_q == ST_ADD) && cur_bit && acc_inf;
    assign launch   = ((state_q == ST_DBL) && !acc_inf) ||
                      ((state_q == ST_ADD) && cur_bit && !acc_inf);
    assign launch_cmd = (state_q == ST_ADD) ? OP_ADD : OP_DOUBLE;
    assign opnd_b     = (state_q == ST_ADD) ? base_q : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (accept) begin
            base_q <= '{x: base_x_i, y: base_y_i};
        end
    end

    smul_scan #(.KW(KW)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .k_in    (scalar_i),
        .advance (scan_adv),
        .bit_o   (cur_bit),
        .last_o  (last_bit)
    );

    smul_acc #(.CW(CW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .copy_en (copy_en),
        .copy_x  (base_q.x),
        .copy_y  (base_q.y),
        .res_en  (op_fin),
        .res_x   (op_rx_i),
        .res_y   (op_ry_i),
        .x_o     (acc.x),
        .y_o     (acc.y),
        .inf_o   (acc_inf)
    );

    smul_opport #(.CW(CW)) u_op (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_cmd (launch_cmd),
        .a_x        (acc.x),
        .a_y        (acc.y),
        .b_x        (opnd_b.x),
        .b_y        (opnd_b.y),
        .done_i     (op_done_i),
        .req_o      (op_req_o),
        .cmd_o      (cmd_q),
        .ax_o       (op_ax_o),
        .ay_o       (op_ay_o),
        .bx_o       (op_bx_o),
        .by_o       (op_by_o),
        .fin_o      (op_fin)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_DBL;
            ST_DBL:      state_d = acc_inf ? ST_ADD : ST_DBL_WAIT;
            ST_DBL_WAIT: if (op_fin) state_d = ST_ADD;
            ST_ADD: begin
                if (!cur_bit || acc_inf) state_d = ST_STEP;
                else                     state_d = ST_ADD_WAIT;
            end
            ST_ADD_WAIT: if (op_fin) state_d = ST_STEP;
            ST_STEP:     state_d = last_bit ? ST_IDLE : ST_DBL;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_STEP) && last_bit;
        end
    end

    assign op_cmd_o = cmd_q;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign q_x_o    = acc.x;
    assign q_y_o    = acc.y;
    assign q_inf_o  = acc_inf;
endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
    parameter int CW = 233
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          op_req_o,
    input logic          op_cmd_o,
    input logic [CW-1:0] op_ax_o,
    input logic [CW-1:0] op_ay_o,
    input logic [CW-1:0] op_bx_o,
    input logic [CW-1:0] op_by_o,
    input logic          op_done_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [CW-1:0] q_x_o,
    input logic [CW-1:0] q_y_o,
    input logic          q_inf_o
);
    // R6: request held with steady command and operands until completion
    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (op_req_o && !op_done_i) |=> (op_req_o && $stable(op_cmd_o) &&
            $stable(op_ax_o) && $stable(op_ay_o) &&
            $stable(op_bx_o) && $stable(op_by_o)));

    // R4 / R5 / R6: no command ever sees an infinity accumulator
    a_r4_no_req_on_inf: assert property (@(posedge clk) disable iff (rst)
        op_req_o |-> !q_inf_o);

    // R6: no request outside a run
    a_r6_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !op_req_o);

    // R7: done is a single-cycle pulse with busy already low
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R7: result frozen while idle and no start is offered
    a_r7_q_frozen: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(q_x_o) && $stable(q_y_o) &&
            $stable(q_inf_o)));
endmodule

bind scalar_mult_ctrl smul_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .op_req_o  (op_req_o),
    .op_cmd_o  (op_cmd_o),
    .op_ax_o   (op_ax_o),
    .op_ay_o   (op_ay_o),
    .op_bx_o   (op_bx_o),
    .op_by_o   (op_by_o),
    .op_done_i (op_done_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .q_x_o     (q_x_o),
    .q_y_o     (q_y_o),
    .q_inf_o   (q_inf_o)
);

// File: tb/scalar_mult_ctrl_tb_top.sv
module scalar_mult_ctrl_tb_top;
    localparam int  KW      = 10;
    localparam int  CW      = 20;
    localparam int  CLK_PER = 10;
    localparam longint MODN = 1000003;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [KW-1:0] scalar_i = '0;
    logic [CW-1:0] base_x_i = '0, base_y_i = '0;
    logic          op_req_o, op_cmd_o, op_done_i = 1'b0;
    logic [CW-1:0] op_ax_o, op_ay_o, op_bx_o, op_by_o;
    logic [CW-1:0] op_rx_i = '0, op_ry_i = '0;
    logic          busy_o, done_o, q_inf_o;
    logic [CW-1:0] q_x_o, q_y_o;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int n_dbl = 0, n_add = 0, lat = 0;
    logic [CW-1:0] cur_px = '0;

    always #(CLK_PER/2) clk = ~clk;

    scalar_mult_ctrl #(.KW(KW), .CW(CW)) dut_i (.*);

    function automatic logic [CW-1:0] ycode(input logic [CW-1:0] x);
        return x ^ CW'(20'h5A3C6);
    endfunction

    function automatic logic [CW-1:0] mulmod(input logic [KW-1:0] k, input logic [CW-1:0] p);
        longint r;
        r = (longint'(k) * longint'(p)) % MODN;
        return CW'(r);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    // point unit model: integers mod MODN, random latency
    initial begin
        forever begin
            @(negedge clk);
            if (op_done_i) begin
                op_done_i = 1'b0;
            end else if (op_req_o) begin
                if (lat == 0) begin
                    longint r;
                    if (op_cmd_o) begin
                        n_add++;
                        // R6: add carries Q on A and P on B
                        chk("R6 add operand B", op_bx_o, cur_px);
                        chk("R6 add operand B y", op_by_o, ycode(cur_px));
                        r = (longint'(op_ax_o) + longint'(op_bx_o)) % MODN;
                    end else begin
                        n_dbl++;
                        // R6: double carries Q on both ports
                        chk("R6 double operands", op_bx_o, op_ax_o);
                        r = (2 * longint'(op_ax_o)) % MODN;
                    end
                    op_rx_i   = CW'(r);
                    op_ry_i   = ycode(CW'(r));
                    op_done_i = 1'b1;
                    lat = int'($urandom_range(0, 2));
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic run_case(input logic [KW-1:0] k, input logic [CW-1:0] px, input bit poke);
        int t, ms, pc;
        logic [CW-1:0] ex;
        while (busy_o) @(negedge clk);
        n_dbl = 0; n_add = 0;
        cur_px   = px;
        scalar_i = k;
        base_x_i = px;
        base_y_i = ycode(px);
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        scalar_i = ~k;               // latched value must be used
        base_x_i = px ^ CW'(1);
        if (poke) begin
            repeat (3) @(negedge clk);
            // R8: start while busy is ignored
            scalar_i = k ^ KW'(3);
            base_x_i = px + CW'(7);
            start_i  = 1'b1;
            @(negedge clk);
            start_i  = 1'b0;
        end
        t = 0;
        while (!done_o && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk("R7 done reached", done_o, 1);
        chk("R7 busy low with done", busy_o, 0);
        ms = -1; pc = 0;
        for (int i = 0; i < KW; i++) if (k[i]) begin ms = i; pc++; end
        if (k == 0) begin
            chk("R9 zero scalar infinity", q_inf_o, 1);
            chk("R9 no commands", n_dbl + n_add, 0);
        end else begin
            ex = mulmod(k, px);
            chk(poke ? "R8 result after ignored start" : "R2 result x", q_x_o, ex);
            chk("R2 result y", q_y_o, ycode(ex));
            chk("R2 infinity clear", q_inf_o, 0);
            chk("R3 R4 double count", n_dbl, ms);
            chk("R3 R5 add count", n_add, pc - 1);
        end
        @(negedge clk);
        chk("R7 done one cycle", done_o, 0);
        repeat (2) @(negedge clk);
        if (k != 0) chk("R7 result held", q_x_o, mulmod(k, px));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 req", op_req_o, 0);
        chk("R1 inf", q_inf_o, 1);
        rst = 1'b0;
        @(negedge clk);

        run_case('0, 20'd777, 1'b0);                 // R9
        run_case(KW'(1), 20'd12345, 1'b0);           // R5 copy only
        run_case({1'b1, {(KW-1){1'b0}}}, 20'd3, 1'b0); // R4 no skip, doubles only
        run_case('1, 20'd99991, 1'b0);               // R3 all adds
        run_case(KW'(2), 20'd500, 1'b0);             // R4 leading zeros skipped
        run_case(KW'(341), 20'd4242, 1'b1);          // R8 poke
        for (int n = 0; n < 40; n++) begin
            logic [KW-1:0] k;
            logic [CW-1:0] p;
            k = KW'($urandom);
            p = CW'($urandom_range(1, 999999));
            run_case(k, p, (n % 5) == 0);
        end
        finish_run();
    end
endmodule